// File: doc/BRIEF.md
# Supply Undervoltage Reset Sequencer

This block turns two comparator flags watching a supervised supply rail into a clean, active-low reset for downstream logic. One flag says the rail is above an upper threshold. The other says it has fallen below a lower threshold. The gap between them gives hysteresis, so one sag produces one reset pulse and not a burst of them.

Reset is released only after the rail has stayed above the upper threshold for a fixed delay. This holds at power-up and after every recovery. Once reset is released, only the lower threshold can pull it back low, and only after the dip has outlasted a blanking filter. The blanking filter and the rest of the reaction together fit inside a bounded reaction time.

A thermal-shutdown flag and a rail-valid flag both force reset low at once, with no blanking. All timing is counted in ticks of a single-cycle enable, nominally one microsecond. Every tick count is a parameter.

Top module: `uvr_seq`

## Requirements
- R1: After the synchronous reset, `rst_out_n` is 0 and stays 0 until `rail_above_hi` has been seen high with `rail_below_lo` low.
- R2: After the rail crosses the upper threshold, `rst_out_n` stays 0 for at least DELAY_TICKS ticks. It reads 1 no later than DELAY_TICKS+2 ticks plus a few clocks after the crossing.
- R3: While `rst_out_n` is 1, `rail_above_hi` going low with `rail_below_lo` still low leaves `rst_out_n` at 1.
- R4: A high pulse on `rail_below_lo` that lasts fewer than BLANK_TICKS-1 tick periods leaves `rst_out_n` at 1.
- R5: A continuous high level on `rail_below_lo` drives `rst_out_n` to 0 within BLANK_TICKS+2 ticks. BLANK_TICKS is capped at REACT_TICKS-2, so the reaction stays below REACT_TICKS ticks.
- R6: Once `rst_out_n` is 0, it stays 0 while `rail_below_lo` remains high. It also stays 0 while the rail sits between the two thresholds.
- R7: Recovery from an undervoltage event uses the same delay as power-up, counted from the new upper-threshold crossing.
- R8: During the release delay, a high on `rail_below_lo` or a low on `rail_above_hi` cancels the delay. The full delay then restarts on the next crossing.
- R9: `therm_sd` high forces `rst_out_n` to 0 within 3 clocks, with no blanking. It stays 0 while `therm_sd` is high. Release then follows R2.
- R10: `rail_valid` low forces `rst_out_n` to 0 within 3 clocks and holds it there. Release then follows R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1us | input | 1 | One-cycle timebase enable |
| rail_above_hi | input | 1 | Comparator: rail above upper threshold (asynchronous) |
| rail_below_lo | input | 1 | Comparator: rail below lower threshold (asynchronous) |
| rail_valid | input | 1 | Rail high enough for the reset output to be driven (asynchronous) |
| therm_sd | input | 1 | Thermal shutdown active (asynchronous) |
| rst_out_n | output | 1 | Registered active-low reset output |

## Verification
The bench builds the block with DELAY_TICKS=25, BLANK_TICKS=4 and REACT_TICKS=8, and supplies a tick every 3 clocks. These values put a full release delay at about 75 clocks. That leaves room for dozens of recoveries, restarts during the delay, and random dips on both sides of the blanking edge. The short blanking window lets dip lengths between 1 and 30 clocks reach both the ignored band and the asserting band.

// File: rtl/uvr_pkg.sv
package uvr_pkg;
  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_DELAY = 2'd1,
    ST_RUN   = 2'd2,
    ST_BLANK = 2'd3
  } uvr_state_t;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/uvr_sync.sv
module uvr_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/uvr_timer.sv
module uvr_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          tick,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                      cnt <= '0;
    else if (load)                cnt <= load_val;
    else if (tick && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/uvr_fsm.sv
module uvr_fsm
  import uvr_pkg::*;
#(
  parameter int CW        = 8,
  parameter int DELAY_VAL = 100,
  parameter int BLANK_VAL = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hi,
  input  logic          lo,
  input  logic          therm,
  input  logic          valid,
  input  logic          tmr_zero,
  output logic          load,
  output logic [CW-1:0] load_val,
  output logic          rst_n_q
);
  localparam logic [CW-1:0] DLY = CW'(DELAY_VAL);
  localparam logic [CW-1:0] BLK = CW'(BLANK_VAL);

  uvr_state_t state, nxt;
  logic       force_low;

  assign force_low = therm | ~valid;

  always_comb begin
    nxt      = state;
    load     = 1'b0;
    load_val = DLY;
    unique case (state)
      ST_HOLD: begin
        if (!force_low && hi && !lo) begin
          nxt  = ST_DELAY;
          load = 1'b1;
        end
      end
      ST_DELAY: begin
        if (force_low || lo || !hi) nxt = ST_HOLD;
        else if (tmr_zero)          nxt = ST_RUN;
      end
      ST_RUN: begin
        if (force_low) nxt = ST_HOLD;
        else if (lo) begin
          nxt      = ST_BLANK;
          load     = 1'b1;
          load_val = BLK;
        end
      end
      ST_BLANK: begin
        if (force_low)     nxt = ST_HOLD;
        else if (!lo)      nxt = ST_RUN;
        else if (tmr_zero) nxt = ST_HOLD;
      end
      default: nxt = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_HOLD;
      rst_n_q <= 1'b0;
    end else begin
      state   <= nxt;
      rst_n_q <= (nxt == ST_RUN) || (nxt == ST_BLANK);
    end
  end
endmodule

// File: rtl/uvr_seq.sv
module uvr_seq
  import uvr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DELAY_TICKS = 16500,
  parameter int BLANK_TICKS = 7,
  parameter int REACT_TICKS = 33
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_1us,
  input  logic rail_above_hi,
  input  logic rail_below_lo,
  input  logic rail_valid,
  input  logic therm_sd,
  output logic rst_out_n
);
  localparam int BLANK_CAP = (BLANK_TICKS > REACT_TICKS - 2) ? REACT_TICKS - 2 : BLANK_TICKS;
  localparam int BLANK_EFF = (BLANK_CAP < 1) ? 1 : BLANK_CAP;
  localparam int DELAY_EFF = (DELAY_TICKS < 1) ? 1 : DELAY_TICKS;
  localparam int CNT_MAX   = int'(max2(DELAY_EFF, BLANK_EFF));
  localparam int CW        = $clog2(CNT_MAX + 1);

  logic [3:0]    flags_s;
  logic          hi_s, lo_s, valid_s, therm_s;
  logic          tmr_load, tmr_zero;
  logic [CW-1:0] tmr_val;

  uvr_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async ({therm_sd, rail_valid, rail_below_lo, rail_above_hi}),
    .q_sync  (flags_s)
  );

  assign hi_s    = flags_s[0];
  assign lo_s    = flags_s[1];
  assign valid_s = flags_s[2];
  assign therm_s = flags_s[3];

  uvr_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .tick     (tick_1us),
    .zero     (tmr_zero)
  );

  uvr_fsm #(.CW(CW), .DELAY_VAL(DELAY_EFF), .BLANK_VAL(BLANK_EFF)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .hi       (hi_s),
    .lo       (lo_s),
    .therm    (therm_s),
    .valid    (valid_s),
    .tmr_zero (tmr_zero),
    .load     (tmr_load),
    .load_val (tmr_val),
    .rst_n_q  (rst_out_n)
  );
endmodule

// File: rtl/uvr_seq_chk.sv
module uvr_seq_chk #(
  parameter int DELAY_TICKS = 16500,
  parameter int REACT_TICKS = 33
) (
  input logic clk,
  input logic rst,
  input logic tick,
  input logic hi_s,
  input logic lo_s,
  input logic therm_s,
  input logic valid_s,
  input logic rst_out_n
);
  localparam int DW = $clog2(DELAY_TICKS + 2);
  localparam int RW = $clog2(REACT_TICKS + 3);

  logic [DW-1:0] dly_cnt;
  logic [RW-1:0] react_cnt;

  always_ff @(posedge clk) begin
    if (rst || !hi_s || lo_s || therm_s || !valid_s) dly_cnt <= '0;
    else if (tick && dly_cnt < DW'(DELAY_TICKS))     dly_cnt <= dly_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !(lo_s && rst_out_n))                  react_cnt <= '0;
    else if (tick && react_cnt < RW'(REACT_TICKS + 1)) react_cnt <= react_cnt + 1'b1;
  end

  AST_RST_LOW: assert property (@(posedge clk) rst |=> !rst_out_n); // R1
  AST_DELAY_MIN: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_out_n) |-> dly_cnt >= DW'(DELAY_TICKS)); // R2
  AST_UPPER_NO_ASSERT: assert property (@(posedge clk) disable iff (rst)
    (rst_out_n && !lo_s && !therm_s && valid_s) |=> rst_out_n); // R3
  AST_REACT_BOUND: assert property (@(posedge clk) disable iff (rst)
    rst_out_n |-> react_cnt < RW'(REACT_TICKS)); // R5
  AST_DIP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!rst_out_n && lo_s) |=> !rst_out_n); // R6
  AST_THERM_FORCE: assert property (@(posedge clk) disable iff (rst)
    therm_s |=> !rst_out_n); // R9
  AST_VALID_FORCE: assert property (@(posedge clk) disable iff (rst)
    !valid_s |=> !rst_out_n); // R10
endmodule

bind uvr_seq uvr_seq_chk #(.DELAY_TICKS(DELAY_TICKS), .REACT_TICKS(REACT_TICKS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick      (tick_1us),
  .hi_s      (hi_s),
  .lo_s      (lo_s),
  .therm_s   (therm_s),
  .valid_s   (valid_s),
  .rst_out_n (rst_out_n)
);

// File: tb/uvr_seq_tb.sv
module uvr_seq_tb;
  localparam int D  = 25;
  localparam int B  = 4;
  localparam int RT = 8;
  localparam int TP = 3;

  logic clk = 1'b0;
  logic rst, tick, hi, lo, valid, therm;
  logic rst_out_n;
  int   tcnt = 0;
  int   total = 0;
  int   bad = 0;

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (tcnt == TP - 1) begin tcnt = 0; tick = 1'b1; end
    else begin tcnt = tcnt + 1; tick = 1'b0; end
  end

  uvr_seq #(.SYNC_STAGES(2), .DELAY_TICKS(D), .BLANK_TICKS(B), .REACT_TICKS(RT)) u_dut (
    .clk(clk), .rst(rst), .tick_1us(tick), .rail_above_hi(hi), .rail_below_lo(lo),
    .rail_valid(valid), .therm_sd(therm), .rst_out_n(rst_out_n)
  );

  function automatic bit dip_asserts(input int len);
    return len >= (B + 2) * TP;
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hold_watch(input int n, input logic lvl, input string req);
    int seen = 1;
    for (int i = 0; i < n; i++) begin
      step(1);
      if (rst_out_n !== lvl) seen = 0;
    end
    chk(req, seen, 1);
  endtask

  task automatic release_check(input string req);
    hi = 1'b1; lo = 1'b0;
    step((D - 1) * TP);
    chk(req, rst_out_n, 0);
    step(3 * TP);
    chk(req, rst_out_n, 1);
  endtask

  task automatic long_dip();
    hi = 1'b0; lo = 1'b1;
    step((B + 2) * TP + 6);
    lo = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cyc;
    int len;
    void'($urandom(32'd4242));
    rst = 1'b1; hi = 1'b0; lo = 1'b1; valid = 1'b0; therm = 1'b0; tick = 1'b0;
    step(5);
    chk("R1 in reset", rst_out_n, 0);
    rst = 1'b0; valid = 1'b1;
    hold_watch(30, 1'b0, "R1 rail low");
    lo = 1'b0;
    hold_watch(20, 1'b0, "R1 between thresholds");
    release_check("R2 power-up delay");

    hi = 1'b0;
    hold_watch(60, 1'b1, "R3 upper loss only");
    hi = 1'b1;

    lo = 1'b1; step(1); lo = 1'b0;
    hold_watch(25, 1'b1, "R4 one-clock spike");
    lo = 1'b1; step((B - 2) * TP); lo = 1'b0;
    hold_watch(25, 1'b1, "R4 longest ignored spike");

    hi = 1'b0; lo = 1'b1; cyc = 0;
    while (rst_out_n === 1'b1 && cyc < 80) begin step(1); cyc++; end
    chk("R5 reaction bound", int'(cyc <= (B + 2) * TP + 4), 1);
    hold_watch(100, 1'b0, "R6 held during dip");
    lo = 1'b0;
    hold_watch(20, 1'b0, "R6 held in hysteresis band");
    release_check("R7 recovery delay");

    long_dip();
    hi = 1'b1; step((D / 2) * TP);
    lo = 1'b1; hi = 1'b0; step(2); lo = 1'b0; hi = 1'b1;
    step((D - 1) * TP);
    chk("R8 restart on dip", rst_out_n, 0);
    step(3 * TP);
    chk("R8 restart on dip", rst_out_n, 1);

    long_dip();
    hi = 1'b1; step((D / 2) * TP);
    hi = 1'b0; step(2); hi = 1'b1;
    step((D - 1) * TP);
    chk("R8 restart on upper loss", rst_out_n, 0);
    step(3 * TP);
    chk("R8 restart on upper loss", rst_out_n, 1);

    therm = 1'b1; step(3);
    chk("R9 thermal force", rst_out_n, 0);
    hold_watch(50, 1'b0, "R9 thermal hold");
    therm = 1'b0;
    release_check("R9 thermal release");

    valid = 1'b0; step(3);
    chk("R10 valid loss", rst_out_n, 0);
    hold_watch(30, 1'b0, "R10 valid hold");
    valid = 1'b1;
    release_check("R10 valid release");

    for (int it = 0; it < 14; it++) begin
      if ($urandom_range(1, 0) == 1) len = $urandom_range((B - 2) * TP, 1);
      else                           len = $urandom_range(30, (B + 2) * TP + 2);
      lo = 1'b1;
      if (dip_asserts(len)) hi = 1'b0;
      step(len);
      lo = 1'b0;
      if (dip_asserts(len)) begin
        step(4);
        chk("R5 random long dip", rst_out_n, 0);
        release_check("R7 random recovery");
      end else begin
        hold_watch(20, 1'b1, "R4 random short spike");
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule